// File: doc/BRIEF.md
# Write-Drain Read/Write Bus Arbiter

This block decides, cycle by cycle, whether a shared bidirectional data bus carries a read or a write. Read requests wait in a small read queue. Write requests wait in a separate write buffer. Each queue accepts requests through its own valid/ready handshake. A single issue port sends out at most one request per cycle. The port has a direction flag, an address and, for writes, the data.

Reads come first. Writes collect in the buffer and go out only when no read is waiting, or in a batch. A batch starts when the buffer fills to a high watermark. In that write-drain mode the arbiter issues writes back to back. It stops when the occupancy reaches a low watermark, and then turns the bus back to reads. Every reversal of the bus costs a fixed number of idle turnaround cycles. The gap between the two watermarks therefore sets how many writes share the cost of one pair of reversals.

The controller has four states:
- `BUS_RD`: the bus is in read direction.
- `BUS_TA_W`: turnaround from read to write.
- `BUS_WR`: the bus is in write direction.
- `BUS_TA_R`: turnaround from write to read.

The transitions are:
- `BUS_RD` goes to `BUS_TA_W` on a drain trigger, or when the read queue is empty and the write buffer is not.
- `BUS_TA_W` goes to `BUS_WR` after TURN_CYC cycles.
- `BUS_WR` goes to `BUS_TA_R` when a drain reaches the low watermark, or when a read arrives outside drain mode.
- `BUS_TA_R` goes to `BUS_RD` after TURN_CYC cycles.

Top module: `rw_drain_arbiter`

## Requirements
- R1: After reset, iss_valid is 0 and iss_write is 0 (read direction), and both rd_ready and wr_ready are 1.
- R2: Outside drain mode, while the bus is in read direction, one queued read issues per cycle, with iss_write=0. Queued writes wait for as long as the read queue holds anything.
- R3: In the first read-direction cycle in which write occupancy is at least HI_MARK (default 6), no read issues and a turnaround toward writes begins. This holds even when reads are queued.
- R4: In drain mode, one write issues per cycle until the occupancy after that issue is at most LO_MARK (default 2). The bus then turns back, and queued reads resume.
- R5: Once a change of direction is decided, iss_valid stays 0 for TURN_CYC cycles (default 3). A read issue and a write issue never occur in adjacent cycles.
- R6: In read direction with an empty read queue and a non-empty write buffer, the bus turns to writes. It issues writes while the read queue stays empty. A read arriving in write direction outside drain mode stops write issue in that cycle and turns the bus back.
- R7: When the write buffer holds WB_DEPTH entries (default 8), wr_ready is 0. A write offered then is discarded and never issued.
- R8: Each queue issues in arrival order. iss_addr carries the issued request's address. For writes, iss_data carries the write data.
- R9: iss_write is 1 exactly while the bus is in write direction, including cycles with no issue. It is 0 in read direction and during both turnarounds. At most one request issues per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read queue can accept a request |
| rd_addr | input | AW | Read address |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write buffer can accept a request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| iss_valid | output | 1 | A request is issued this cycle |
| iss_write | output | 1 | Bus direction: 1 write, 0 read |
| iss_addr | output | AW | Address of the issued request |
| iss_data | output | DW | Data of the issued write (0 for reads) |

## Verification
A request accepted at a clock edge can issue in the very next cycle, because the issue outputs depend only on registered queue and state contents. A drain trigger is seen one cycle after the edge that brings occupancy to HI_MARK. The first write then follows TURN_CYC+1 cycles later. The bench drives inputs just after each falling edge. Since no output depends combinationally on an input, the outputs at that moment show the current cycle. Each table row therefore holds the inputs for that cycle and the outputs expected in that same cycle, counted edge by edge from the requirements. The full-buffer test records every issue in order and compares the whole stream.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;

    typedef enum logic [1:0] {
        BUS_RD   = 2'd0,
        BUS_TA_W = 2'd1,
        BUS_WR   = 2'd2,
        BUS_TA_R = 2'd3
    } bus_state_e;

endpackage

// File: rtl/wdq_fifo.sv
module wdq_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             push_en;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign push_en = push && !full;
    assign count   = cnt_q;
    assign dout    = mem[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_en) wp_q <= bump(wp_q);
            if (pop)     rp_q <= bump(rp_q);
            case ({push_en, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) mem[wp_q] <= din;
    end

    // R8
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/wdrain_ctrl.sv
module wdrain_ctrl
    import wdrain_pkg::*;
#(
    parameter int RCNT_W   = 3,
    parameter int WCNT_W   = 4,
    parameter int HI_MARK  = 6,
    parameter int LO_MARK  = 2,
    parameter int TURN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RCNT_W-1:0] rq_count,
    input  logic [WCNT_W-1:0] wq_count,
    input  logic              wq_push,
    output logic              rd_pop,
    output logic              wr_pop,
    output logic              iss_valid,
    output logic              iss_write
);

    localparam int TC_W = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;

    bus_state_e        state_q, state_d;
    logic [TC_W-1:0]   tc_q, tc_d;
    logic              drain_q, drain_d;
    logic              rq_empty, wq_empty, hi_hit, draining, turn_done;
    logic [WCNT_W:0]   post_cnt;

    assign rq_empty  = (rq_count == '0);
    assign wq_empty  = (wq_count == '0);
    assign hi_hit    = (wq_count >= WCNT_W'(HI_MARK));
    assign draining  = drain_q || hi_hit;
    assign turn_done = (tc_q == TC_W'(TURN_CYC - 1));
    assign post_cnt  = {1'b0, wq_count} + {{WCNT_W{1'b0}}, wq_push}
                     - {{WCNT_W{1'b0}}, 1'b1};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_RD;
            tc_q    <= '0;
            drain_q <= 1'b0;
        end else begin
            state_q <= state_d;
            tc_q    <= tc_d;
            drain_q <= drain_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        tc_d    = '0;
        drain_d = draining;
        unique case (state_q)
            BUS_RD: begin
                if (draining || (rq_empty && !wq_empty)) state_d = BUS_TA_W;
            end
            BUS_TA_W: begin
                if (turn_done) state_d = BUS_WR;
                else           tc_d    = tc_q + 1'b1;
            end
            BUS_WR: begin
                if (draining) begin
                    if (post_cnt <= (WCNT_W + 1)'(LO_MARK)) begin
                        state_d = BUS_TA_R;
                        drain_d = 1'b0;
                    end
                end else if (!rq_empty) begin
                    state_d = BUS_TA_R;
                end
            end
            BUS_TA_R: begin
                if (turn_done) state_d = BUS_RD;
                else           tc_d    = tc_q + 1'b1;
            end
        endcase
    end

    // outputs
    always_comb begin
        rd_pop    = 1'b0;
        wr_pop    = 1'b0;
        iss_write = 1'b0;
        unique case (state_q)
            BUS_RD:   rd_pop = !draining && !rq_empty;
            BUS_WR: begin
                iss_write = 1'b1;
                wr_pop    = (draining || rq_empty) && !wq_empty;
            end
            BUS_TA_W, BUS_TA_R: ;
        endcase
        iss_valid = rd_pop || wr_pop;
    end

    // R2
    rd_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pop && !drain_q && !hi_hit) |-> rq_empty);

    // R3
    drain_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_hit |=> drain_q);

    // R4
    drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drain_q) |-> (wq_count <= WCNT_W'(LO_MARK)));

    // R5
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_write) |=> !(iss_valid && iss_write));

    // R5
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_write) |=> !(iss_valid && !iss_write));

    // R9
    one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_pop, wr_pop}));

endmodule

// File: rtl/rw_drain_arbiter.sv
module rw_drain_arbiter #(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int RQ_DEPTH = 4,
    parameter int WB_DEPTH = 8,
    parameter int HI_MARK  = 6,
    parameter int LO_MARK  = 2,
    parameter int TURN_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          iss_valid,
    output logic          iss_write,
    output logic [AW-1:0] iss_addr,
    output logic [DW-1:0] iss_data
);

    localparam int RCNT_W = $clog2(RQ_DEPTH + 1);
    localparam int WCNT_W = $clog2(WB_DEPTH + 1);
    localparam int WE_W   = AW + DW;

    logic [AW-1:0]     rq_head;
    logic [WE_W-1:0]   wq_head;
    logic [RCNT_W-1:0] rq_count;
    logic [WCNT_W-1:0] wq_count;
    logic              rq_full, wq_full, rd_pop, wr_pop, wq_push;

    assign rd_ready = !rq_full;
    assign wr_ready = !wq_full;
    assign wq_push  = wr_valid && !wq_full;

    wdq_fifo #(.DEPTH(RQ_DEPTH), .WIDTH(AW)) u_rdq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rd_valid),
        .din   (rd_addr),
        .pop   (rd_pop),
        .dout  (rq_head),
        .count (rq_count),
        .full  (rq_full)
    );

    wdq_fifo #(.DEPTH(WB_DEPTH), .WIDTH(WE_W)) u_wrb (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_valid),
        .din   ({wr_addr, wr_data}),
        .pop   (wr_pop),
        .dout  (wq_head),
        .count (wq_count),
        .full  (wq_full)
    );

    wdrain_ctrl #(
        .RCNT_W   (RCNT_W),
        .WCNT_W   (WCNT_W),
        .HI_MARK  (HI_MARK),
        .LO_MARK  (LO_MARK),
        .TURN_CYC (TURN_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rq_count  (rq_count),
        .wq_count  (wq_count),
        .wq_push   (wq_push),
        .rd_pop    (rd_pop),
        .wr_pop    (wr_pop),
        .iss_valid (iss_valid),
        .iss_write (iss_write)
    );

    assign iss_addr = iss_write ? wq_head[WE_W-1:DW] : rq_head;
    assign iss_data = iss_write ? wq_head[DW-1:0]    : '0;

endmodule

// File: tb/rw_drain_arbiter_test.sv
`timescale 1ns/1ps
module rw_drain_arbiter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_valid = 1'b0, wr_valid = 1'b0;
    logic [7:0] rd_addr = '0, wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic       rd_ready, wr_ready, iss_valid, iss_write;
    logic [7:0] iss_addr;
    logic [15:0] iss_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rw_drain_arbiter uut (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .iss_valid(iss_valid), .iss_write(iss_write), .iss_addr(iss_addr), .iss_data(iss_data)
    );

    typedef struct packed {
        logic       rv;
        logic [7:0] ra;
        logic       wv;
        logic [7:0] wa;
        logic       ev;
        logic       ed;
        logic [7:0] ea;
        logic [3:0] rq;
    } vec_t;

    localparam vec_t VEC [39] = '{
        '{1'b1, 8'd1,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd1}, // R1
        '{1'b1, 8'd2,  1'b0, 8'd0,  1'b1, 1'b0, 8'd1,  4'd8}, // R8
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 8'd2,  4'd8},
        '{1'b0, 8'd0,  1'b1, 8'd10, 1'b0, 1'b0, 8'd0,  4'd6}, // R6
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd6},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5}, // R5
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b1, 8'd3,  1'b0, 8'd0,  1'b1, 1'b1, 8'd10, 4'd6},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b1, 8'd0,  4'd6},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 8'd3,  4'd5},
        '{1'b1, 8'd20, 1'b1, 8'd30, 1'b0, 1'b0, 8'd0,  4'd2}, // R2
        '{1'b1, 8'd21, 1'b1, 8'd31, 1'b1, 1'b0, 8'd20, 4'd2},
        '{1'b1, 8'd22, 1'b1, 8'd32, 1'b1, 1'b0, 8'd21, 4'd2},
        '{1'b1, 8'd23, 1'b1, 8'd33, 1'b1, 1'b0, 8'd22, 4'd2},
        '{1'b1, 8'd24, 1'b1, 8'd34, 1'b1, 1'b0, 8'd23, 4'd2},
        '{1'b1, 8'd25, 1'b1, 8'd35, 1'b1, 1'b0, 8'd24, 4'd3}, // R3
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd3},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b1, 8'd30, 4'd4}, // R4
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b1, 8'd31, 4'd4},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b1, 8'd32, 4'd4},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b1, 8'd33, 4'd4},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 8'd25, 4'd4},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd6},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  4'd5},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b1, 8'd34, 4'd6},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b1, 8'd35, 4'd6},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b1, 8'd0,  4'd9}  // R9
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic rv, input logic [7:0] ra,
                        input logic wv, input logic [7:0] wa);
        @(negedge clk);
        rd_valid = rv;
        rd_addr  = ra;
        wr_valid = wv;
        wr_addr  = wa;
        wr_data  = {wa, ~wa};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rd_valid = 1'b0;
        wr_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reset_checks();
        // R1: idle, read direction, both queues accepting
        chk(iss_valid == 1'b0, "R1", "iss_valid", int'(iss_valid), 0);
        chk(iss_write == 1'b0, "R1", "iss_write", int'(iss_write), 0);
        chk(rd_ready == 1'b1, "R1", "rd_ready", int'(rd_ready), 1);
        chk(wr_ready == 1'b1, "R1", "wr_ready", int'(wr_ready), 1);
    endtask

    initial begin
        logic [7:0]  got_a [32];
        logic        got_w [32];
        logic [15:0] got_d [32];
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_checks();

        // table walk
        for (int i = 0; i < 39; i++) begin
            int act, exp;
            tick(VEC[i].rv, VEC[i].ra, VEC[i].wv, VEC[i].wa);
            act = {iss_valid, iss_write, (iss_valid ? iss_addr : 8'd0)};
            exp = {VEC[i].ev, VEC[i].ed, (VEC[i].ev ? VEC[i].ea : 8'd0)};
            chk(act == exp, $sformatf("R%0d", VEC[i].rq),
                $sformatf("row %0d {valid,write,addr}", i), act, exp);
            if (VEC[i].ev && VEC[i].ed)
                chk(iss_data == {VEC[i].ea, ~VEC[i].ea}, "R8",
                    $sformatf("row %0d data", i), int'(iss_data),
                    int'({VEC[i].ea, ~VEC[i].ea}));
        end

        // reset in the middle of activity
        do_reset();
        reset_checks();

        // full buffer: drain from 8 entries, rejected writes carry addr EE
        n = 0;
        for (int d = 0; d < 32; d++) begin
            tick(d <= 5, 8'(40 + d), d <= 9, (d <= 7) ? 8'(50 + d) : 8'hEE);
            if (d == 8 || d == 9)
                chk(wr_ready == 1'b0, "R7", $sformatf("wr_ready at step %0d", d),
                    int'(wr_ready), 0);
            if (iss_valid && n < 32) begin
                got_a[n] = iss_addr;
                got_w[n] = iss_write;
                got_d[n] = iss_data;
                n++;
            end
        end
        // R7 R4 R8: reads 40..44, drain 50..55, read 45, then 56, 57
        chk(n == 14, "R7", "issue count", n, 14);
        for (int k = 0; k < 14 && k < n; k++) begin
            logic       ew;
            logic [7:0] ea;
            if (k < 5)        begin ew = 1'b0; ea = 8'(40 + k); end
            else if (k < 11)  begin ew = 1'b1; ea = 8'(50 + k - 5); end
            else if (k == 11) begin ew = 1'b0; ea = 8'd45; end
            else              begin ew = 1'b1; ea = 8'(56 + k - 12); end
            chk({got_w[k], got_a[k]} == {ew, ea}, (k >= 5 && k < 11) ? "R4" : "R8",
                $sformatf("issue %0d {write,addr}", k),
                int'({got_w[k], got_a[k]}), int'({ew, ea}));
            if (ew)
                chk(got_d[k] == {ea, ~ea}, "R8", $sformatf("issue %0d data", k),
                    int'(got_d[k]), int'({ea, ~ea}));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule